// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block is the power-mode unit of a small microcontroller. It holds a two-bit mode register that the CPU writes: one bit asks for idle, the other for power-down. From that register it drives three enables. One gates the CPU core clock. One gates the peripheral clock (timers, serial port, interrupt logic). One lets the oscillator run. The clock gates themselves, the oscillator, the core and the peripherals sit outside the block and only see these enables.

Idle stops only the CPU clock. A pending enabled interrupt ends idle, and so does a qualified hardware reset. Power-down stops everything, and only a qualified hardware reset ends it. The reset pin is qualified by counting: it must be seen high for two machine cycles of twelve oscillator clocks each. Only then does the block raise its internal core reset.

A qualified reset can end idle. During such a reset the block raises two signals. The first tells the core to keep its program counter, so execution goes on at the instruction after the one that entered idle. The second blocks on-chip RAM access. Port access is not blocked. All state sits in plain flip-flops with no timeouts, so the clock may stop for any length of time without loss.

Top module: `pmc_top`

## Requirements
- R1: Writing the mode register with bit 0 (idle) set and bit 1 clear drops `cpu_clk_en` from the next clock edge, while `periph_clk_en` and `osc_run` stay high.
- R2: Writing bit 1 (power-down) set drops `cpu_clk_en`, `periph_clk_en` and `osc_run` from the next clock edge.
- R3: A write with both bits set enters power-down, and the readback on `mode_rd` shows bit 1 set and bit 0 clear.
- R4: In idle, a high `irq_pend` sampled at an edge clears the idle bit at that edge, and `cpu_clk_en` is high from then on. In power-down or normal running, `irq_pend` changes nothing.
- R5: `hw_rst` is accepted only after it is sampled high on 24 consecutive edges (2 machine cycles of 12 clocks). `core_rst` rises at the 24th such edge. A pulse of 23 edges or fewer has no effect on any output.
- R6: An accepted reset clears both mode bits and restores all three enables at the edge where it is accepted. Power-down is left by no other means.
- R7: `warm_rst` and `ram_inhibit` are high for the whole `core_rst` period exactly when that reset was accepted while idle. They are low otherwise.
- R8: Mode register writes are ignored while in idle, in power-down, or while `core_rst` is high.
- R9: Idle and power-down persist for any number of cycles when no interrupt or accepted reset arrives.
- R10: `core_rst`, `warm_rst` and `ram_inhibit` fall at the first edge that samples `hw_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst | input | 1 | External reset pin, active high, unqualified |
| reg_wr | input | 1 | Mode register write strobe from the CPU |
| reg_wdata | input | REG_W | Write data: bit 0 idle, bit 1 power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| mode_rd | output | REG_W | Mode register readback |
| cpu_clk_en | output | 1 | CPU core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Qualified internal reset |
| warm_rst | output | 1 | Core keeps its program counter during this reset |
| ram_inhibit | output | 1 | Blocks on-chip RAM access; ports stay usable |

## Verification
Results fall due at different times after their stimulus:
- Every mode change and enable change shows up after exactly one edge from the strobe, interrupt or accepted reset.
- `core_rst` rises on the 24th consecutive high sample of `hw_rst`, and on no earlier sample.
- `core_rst` falls on the first low sample.

The bench drives inputs on falling edges and updates a behavioural model at each rising edge. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Directed checks probe the 23- and 24-edge reset lengths, and check for interrupts and writes that must change nothing.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   // Enable bundle handed from the gate stage to the top
   typedef struct packed {
      logic cpu;
      logic periph;
      logic osc;
   } pmc_en_t;

   // Width of a counter that must reach the value lim
   function automatic int unsigned cnt_w(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
   parameter int unsigned CLKS_PER_MC = 12,
   parameter int unsigned RST_MC      = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic hw_rst,
   output logic rst_hit
);
   import pmc_pkg::*;

   localparam int unsigned RST_MIN = CLKS_PER_MC * RST_MC;
   localparam int unsigned CW      = cnt_w(RST_MIN);
   localparam logic [CW-1:0] LIM   = CW'(RST_MIN);
   localparam logic [CW-1:0] LIM_M1 = CW'(RST_MIN - 1);

   logic [CW-1:0] hi_cnt;

   // High-sample counter, saturating at the qualification length
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hi_cnt <= '0;
      end else if (!hw_rst) begin
         hi_cnt <= '0;
      end else if (hi_cnt != LIM) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // The edge that samples the RST_MIN-th consecutive high level accepts
   assign rst_hit = hw_rst && (hi_cnt >= LIM_M1);

endmodule

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg #(
   parameter int unsigned REG_W    = 2,
   parameter int unsigned IDLE_BIT = 0,
   parameter int unsigned PD_BIT   = 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hw_rst,
   input  logic             rst_hit,
   input  logic             irq_pend,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic             idle_q,
   output logic             pd_q,
   output logic             rst_act_q,
   output logic             resume_q
);

   logic wr_ok;

   // Writes only land while the CPU is clocked and no reset is running
   assign wr_ok = reg_wr && !idle_q && !pd_q && !rst_act_q && !rst_hit;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         idle_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (rst_hit) begin
         idle_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (idle_q && !pd_q && irq_pend) begin
         idle_q <= 1'b0;
      end else if (wr_ok) begin
         if (reg_wdata[PD_BIT]) begin
            pd_q   <= 1'b1;
            idle_q <= 1'b0;
         end else begin
            idle_q <= reg_wdata[IDLE_BIT];
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rst_act_q <= 1'b0;
         resume_q  <= 1'b0;
      end else if (rst_hit) begin
         rst_act_q <= 1'b1;
         if (!rst_act_q) begin
            resume_q <= idle_q;
         end
      end else if (!hw_rst) begin
         rst_act_q <= 1'b0;
         resume_q  <= 1'b0;
      end
   end

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!por_n)
      !(idle_q && pd_q)); // R3
   AST_WR_PRIO: assert property (@(posedge clk) disable iff (!por_n)
      wr_ok && reg_wdata[PD_BIT] |=> pd_q && !idle_q); // R3
   AST_PD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      pd_q && !rst_hit |=> pd_q); // R6
   AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!por_n)
      idle_q && irq_pend && !rst_hit |=> !idle_q); // R4
   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      rst_act_q |-> !idle_q && !pd_q); // R6
   AST_RST_DROP: assert property (@(posedge clk) disable iff (!por_n)
      !hw_rst |=> !rst_act_q && !resume_q); // R10
   AST_RESUME_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
      resume_q |-> rst_act_q); // R7

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate #(
   parameter bit ENABLE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             idle_q,
   input  logic             pd_q,
   output pmc_pkg::pmc_en_t en
);
   import pmc_pkg::*;

   pmc_en_t en_d;

   always_comb begin
      en_d.cpu    = !idle_q && !pd_q;
      en_d.periph = !pd_q;
      en_d.osc    = !pd_q;
   end

   generate
      if (ENABLE_REG) begin : g_reg
         pmc_en_t en_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) en_q <= '1;
            else        en_q <= en_d;
         end
         assign en = en_q;
      end else begin : g_comb
         assign en = en_d;
      end
   endgenerate

endmodule

// File: rtl/pmc_top.sv
module pmc_top #(
   parameter int unsigned CLKS_PER_MC = 12,
   parameter int unsigned RST_MC      = 2,
   parameter int unsigned REG_W       = 2,
   parameter int unsigned IDLE_BIT    = 0,
   parameter int unsigned PD_BIT      = 1,
   parameter bit          ENABLE_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hw_rst,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             irq_pend,
   output logic [REG_W-1:0] mode_rd,
   output logic             cpu_clk_en,
   output logic             periph_clk_en,
   output logic             osc_run,
   output logic             core_rst,
   output logic             warm_rst,
   output logic             ram_inhibit
);
   import pmc_pkg::*;

   generate
      if (REG_W < 2) begin : g_bad_w
         $error("pmc_top: REG_W must be at least 2");
      end
      if (IDLE_BIT == PD_BIT || IDLE_BIT >= REG_W || PD_BIT >= REG_W) begin : g_bad_bits
         $error("pmc_top: mode bit positions invalid");
      end
      if (CLKS_PER_MC < 1 || RST_MC < 1) begin : g_bad_len
         $error("pmc_top: reset qualification length must be nonzero");
      end
   endgenerate

   logic    rst_hit;
   logic    idle_q;
   logic    pd_q;
   logic    rst_act_q;
   logic    resume_q;
   pmc_en_t en;

   pmc_rst_filter #(
      .CLKS_PER_MC (CLKS_PER_MC),
      .RST_MC      (RST_MC)
   ) u_filt (
      .clk     (clk),
      .por_n   (por_n),
      .hw_rst  (hw_rst),
      .rst_hit (rst_hit)
   );

   pmc_mode_reg #(
      .REG_W    (REG_W),
      .IDLE_BIT (IDLE_BIT),
      .PD_BIT   (PD_BIT)
   ) u_mode (
      .clk       (clk),
      .por_n     (por_n),
      .hw_rst    (hw_rst),
      .rst_hit   (rst_hit),
      .irq_pend  (irq_pend),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .idle_q    (idle_q),
      .pd_q      (pd_q),
      .rst_act_q (rst_act_q),
      .resume_q  (resume_q)
   );

   pmc_clk_gate #(
      .ENABLE_REG (ENABLE_REG)
   ) u_gate (
      .clk    (clk),
      .por_n  (por_n),
      .idle_q (idle_q),
      .pd_q   (pd_q),
      .en     (en)
   );

   always_comb begin
      mode_rd           = '0;
      mode_rd[IDLE_BIT] = idle_q;
      mode_rd[PD_BIT]   = pd_q;
   end

   assign cpu_clk_en    = en.cpu;
   assign periph_clk_en = en.periph;
   assign osc_run       = en.osc;
   assign core_rst      = rst_act_q;
   assign warm_rst      = rst_act_q && resume_q;
   assign ram_inhibit   = rst_act_q && resume_q;

   AST_INHIBIT_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
      ram_inhibit |-> core_rst); // R7
   AST_RST_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_rst) |-> $past(hw_rst)); // R5

endmodule

// File: tb/pmc_top_bench.sv
module pmc_top_bench;

   localparam int CLK_HALF = 5;
   localparam int RST_MIN  = 24;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       hw_rst = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_wdata = 2'b00;
   logic       irq_pend = 1'b0;
   logic [1:0] mode_rd;
   logic       cpu_clk_en, periph_clk_en, osc_run, core_rst, warm_rst, ram_inhibit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model state
   int m_cnt = 0;
   bit m_idle = 0, m_pd = 0, m_act = 0, m_res = 0;

   always #CLK_HALF clk = ~clk;

   pmc_top u_pmc_top (
      .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .irq_pend(irq_pend), .mode_rd(mode_rd),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_run(osc_run),
      .core_rst(core_rst), .warm_rst(warm_rst), .ram_inhibit(ram_inhibit)
   );

   always @(posedge clk) begin
      if (por_n) begin
         bit hit;
         hit = hw_rst && (m_cnt >= RST_MIN - 1);
         if (hit) begin
            if (!m_act) m_res <= m_idle;
            m_act  <= 1;
            m_idle <= 0;
            m_pd   <= 0;
         end else begin
            if (!hw_rst) begin
               m_act <= 0;
               m_res <= 0;
            end
            if (m_idle && !m_pd && irq_pend) m_idle <= 0;
            else if (reg_wr && !m_idle && !m_pd && !m_act) begin
               if (reg_wdata[1]) begin m_pd <= 1; m_idle <= 0; end
               else m_idle <= reg_wdata[0];
            end
         end
         m_cnt <= hw_rst ? ((m_cnt < RST_MIN) ? m_cnt + 1 : m_cnt) : 0;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare against the model on every falling edge
   always @(negedge clk) begin
      if (por_n && !done) begin
         chk("R1", "cpu_clk_en", cpu_clk_en, !m_idle && !m_pd);
         chk("R2", "periph_clk_en", periph_clk_en, !m_pd);
         chk("R2", "osc_run", osc_run, !m_pd);
         chk("R3", "mode_rd", mode_rd, {m_pd, m_idle});
         chk("R5", "core_rst", core_rst, m_act);
         chk("R7", "warm_rst", warm_rst, m_act && m_res);
         chk("R7", "ram_inhibit", ram_inhibit, m_act && m_res);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      step(1);
      reg_wr = 1'b0; reg_wdata = 2'b00;
   endtask

   task automatic pin_rst(input int n);
      hw_rst = 1'b1;
      step(n);
      hw_rst = 1'b0;
   endtask

   initial begin
      step(3);
      por_n = 1'b1;
      step(1);
      // Reset state
      chk("R6", "reset mode", mode_rd, 0);
      chk("R6", "reset osc", osc_run, 1);
      chk("R5", "reset core_rst", core_rst, 0);

      // R1 idle entry
      wr(2'b01);
      chk("R1", "idle cpu", cpu_clk_en, 0);
      chk("R1", "idle periph", periph_clk_en, 1);
      // R9 hold, R8 write ignored, R4 wake
      step(300);
      chk("R9", "idle held", mode_rd, 1);
      wr(2'b10);
      chk("R8", "write in idle", mode_rd, 1);
      irq_pend = 1'b1; step(1); irq_pend = 1'b0;
      chk("R4", "irq wake cpu", cpu_clk_en, 1);
      chk("R4", "irq wake mode", mode_rd, 0);
      irq_pend = 1'b1; step(2); irq_pend = 1'b0;
      chk("R4", "irq while running", mode_rd, 0);

      // R5 short reset during idle
      wr(2'b01);
      pin_rst(RST_MIN - 1);
      step(1);
      chk("R5", "short pulse core_rst", core_rst, 0);
      chk("R5", "short pulse idle kept", mode_rd, 1);
      // Exact length reset ends idle
      hw_rst = 1'b1;
      step(RST_MIN - 1);
      chk("R5", "not yet", core_rst, 0);
      step(1);
      chk("R5", "accepted", core_rst, 1);
      chk("R7", "warm", warm_rst, 1);
      chk("R7", "ram_inhibit", ram_inhibit, 1);
      chk("R6", "idle cleared", mode_rd, 0);
      wr(2'b01);
      chk("R8", "write in reset", mode_rd, 0);
      step(4);
      hw_rst = 1'b0;
      step(1);
      chk("R10", "core_rst fall", core_rst, 0);
      chk("R10", "inhibit fall", ram_inhibit, 0);

      // Power-down
      wr(2'b10);
      chk("R2", "pd osc", osc_run, 0);
      chk("R2", "pd cpu", cpu_clk_en, 0);
      irq_pend = 1'b1; step(5); irq_pend = 1'b0;
      chk("R4", "irq in pd", mode_rd, 2);
      wr(2'b01);
      chk("R8", "write in pd", mode_rd, 2);
      step(200);
      chk("R9", "pd held", osc_run, 0);
      pin_rst(RST_MIN + 3);
      chk("R7", "cold reset warm", warm_rst, 0);
      chk("R6", "pd left", osc_run, 1);
      step(1);

      // R3 both bits
      wr(2'b11);
      chk("R3", "both bits", mode_rd, 2);
      chk("R3", "both bits osc", osc_run, 0);
      pin_rst(RST_MIN);
      chk("R6", "pd left again", mode_rd, 0);
      step(1);
      // Reset while running gives no warm flag
      pin_rst(RST_MIN + 2);
      step(2);
      chk("R7", "running reset", ram_inhibit, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule